// File: doc/BRIEF.md
# Preloadable Timer/Event Counter with Wake-up

This block is an 8-bit up-counter for a small microcontroller. Software loads a start value into a preload register and picks a count source. The source is either the system clock divided by a programmable power of two (timer mode) or a chosen edge on an external pin (event mode). The count runs from the preload value up to all-ones. On the next count edge the counter reloads the preload value, latches an interrupt request and, while the device is powered down, gives a power controller a one-cycle wake pulse.

Software reaches the block through a small register port. Address 0 reads the live count and writes the preload value. Address 1 holds the control register. Address 2 holds the interrupt enable and the request flag. A count edge that lands in a cycle where software reads the count, or writes the preload, is dropped and not retried. Software can also set the request flag by hand before power-down so that a later overflow does not wake the device.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register (address 1) and the interrupt register (address 2) read back 0x00, and irq and wake are low.
- R2: In timer mode (control bit 5 = 0) with control bit 4 set, the count advances by one every 2^(n+1) clock cycles, where n is control bits [2:0]. The first advance comes 2^(n+1) cycles after the write that sets bit 4.
- R3: While control bit 4 is clear, the count holds its value whatever happens on the count sources.
- R4: A count edge at 0xFF loads the preload value into the counter on that same edge instead of wrapping to 0x00, and sets the request flag (address 2, bit 1).
- R5: irq is high exactly when the request flag and the interrupt enable (address 2, bit 0) are both set.
- R6: Writing address 2 sets the enable to bit 0 and the flag to bit 1 of the written data, so writing 0 to bit 1 clears the flag. When an overflow falls in the same cycle as a write that clears the flag, the flag ends up set.
- R7: A count edge is lost in any cycle where address 0 is read (reg_rd) or written (reg_wr).
- R8: In event mode (control bit 5 = 1) the count advances once for each edge of ext_in after a two-flop synchronizer. Control bit 3 picks the edge: 0 counts rising edges, 1 counts falling edges. Edges of the other polarity are not counted.
- R9: An overflow while pwr_down is high makes wake high for exactly one cycle, in the cycle after the overflow, whether or not the interrupt is enabled.
- R10: No wake pulse comes from an overflow that happens while the request flag is already set, or while pwr_down is low.
- R11: A write to address 0 loads both the preload and the counter while bit 4 is clear, and only the preload while bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select: 0 count/preload, 1 control, 2 interrupt |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; a read of address 0 blocks that cycle's count edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_in | input | 1 | External event input, asynchronous |
| pwr_down | input | 1 | High while the device is in power-down |
| irq | output | 1 | Interrupt request, gated by the enable bit |
| wake | output | 1 | One-cycle wake-up pulse for the power controller |

## Verification
The bench steps through every prescaler ratio class, including the first-edge delay and the longest divide. A ratio that is off by one shows up as a wrong count. It puts a count read and a preload write right on a tick edge. A design that deferred the tick, or let the write reach the running counter, would read back one too many or the new preload. Overflows are timed to land on a flag-clearing write, on a flag that is already set, with the enable off, and with pwr_down low. A design that let the clear win, woke on a pending flag, tied wake to the enable, or stretched the pulse would show the wrong flag or the wrong number of wake cycles. In event mode, rising and falling selections are run on the same pulse trains, which catches a counter that takes both edges.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Width of the prescaler select field; divide ratio is 2^(sel+1).
  localparam int PSC_W = 3;

  // Register selects on the access port.
  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_INT   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Control register, packed MSB first: bit 5 event mode, bit 4 run,
  // bit 3 falling-edge select, bits 2:0 prescaler select.
  typedef struct packed {
    logic             evt_mode;
    logic             run;
    logic             fall_edge;
    logic [PSC_W-1:0] psc_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evt_timer_psc.sv
module evt_timer_psc
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             enable,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = 1 << PSC_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] mask_w;

  // Low (sel+1) bits set; the counter ticks when they are all ones.
  assign mask_w = (DIV_W'(2) << sel) - DIV_W'(1);
  assign tick   = enable && ((div_q & mask_w) == mask_w);

  always_comb begin
    if (enable) begin
      div_d = div_q + DIV_W'(1);
    end else begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/evt_timer_sync_edge.sv
module evt_timer_sync_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic din,
  input  logic fall_sel,
  output logic edge_o
);

  localparam int LAST = SYNC_N - 1;

  // Stages 0..SYNC_N-1 synchronize; stage SYNC_N holds the previous value.
  logic [SYNC_N:0] stage_q;
  logic [SYNC_N:0] stage_d;
  logic            cur_w;
  logic            prev_w;

  assign stage_d = {stage_q[SYNC_N-1:0], din};
  assign cur_w   = stage_q[LAST];
  assign prev_w  = stage_q[SYNC_N];

  always_comb begin
    if (fall_sel) begin
      edge_o = prev_w && !cur_w;
    end else begin
      edge_o = cur_w && !prev_w;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             tick,
  input  logic             load_cnt,
  input  logic             load_pre,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pre_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] pre_d;

  assign ovf_o = tick && (cnt_q == TOP);

  always_comb begin
    pre_d = pre_q;
    if (load_pre) begin
      pre_d = wdata;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_cnt) begin
      cnt_d = wdata;
    end else if (ovf_o) begin
      cnt_d = pre_q;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  // Count and preload are left unreset: software loads them before use.
  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
    pre_q <= pre_d;
  end

  assign cnt_o = cnt_q;
  assign pre_o = pre_q;

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst_ni,
  input  logic ovf,
  input  logic pwr_down,
  input  logic wr_int,
  input  logic wr_en_bit,
  input  logic wr_flag_bit,
  output logic flag_o,
  output logic ien_o,
  output logic irq,
  output logic wake
);

  logic flag_q, flag_d;
  logic ien_q, ien_d;
  logic wake_q, wake_d;

  always_comb begin
    flag_d = flag_q;
    ien_d  = ien_q;
    if (wr_int) begin
      flag_d = wr_flag_bit;
      ien_d  = wr_en_bit;
    end
    if (ovf) begin
      flag_d = 1'b1;
    end
    wake_d = ovf && pwr_down && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
      wake_q <= wake_d;
    end
  end

  assign flag_o = flag_q;
  assign ien_o  = ien_q;
  assign irq    = flag_q && ien_q;
  assign wake   = wake_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ext_in,
  input  logic             pwr_down,
  output logic             irq,
  output logic             wake
);

  localparam int RST_N = 2;

  // Reset: asserted asynchronously, released through a short flop chain.
  logic [RST_N-1:0] rst_pipe_q;
  logic             rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_N-2:0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe_q[RST_N-1];

  // Register decode.
  logic sel_cnt, sel_ctrl, sel_int;
  logic wr_cnt, wr_ctrl, wr_int;
  logic block_w;

  assign sel_cnt  = (reg_addr == SEL_COUNT);
  assign sel_ctrl = (reg_addr == SEL_CTRL);
  assign sel_int  = (reg_addr == SEL_INT);
  assign wr_cnt   = reg_wr && sel_cnt;
  assign wr_ctrl  = reg_wr && sel_ctrl;
  assign wr_int   = reg_wr && sel_int;
  assign block_w  = sel_cnt && (reg_rd || reg_wr);

  // Control register.
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  logic run_q;
  assign run_q = ctrl_q.run;

  // Count sources.
  logic psc_tick, ext_edge, src_w, tick_w;

  evt_timer_psc u_psc (
    .clk    (clk),
    .rst_ni (rst_ni),
    .enable (run_q && !ctrl_q.evt_mode),
    .sel    (ctrl_q.psc_sel),
    .tick   (psc_tick)
  );

  evt_timer_sync_edge #(
    .SYNC_N (SYNC_N)
  ) u_edge (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .din      (ext_in),
    .fall_sel (ctrl_q.fall_edge),
    .edge_o   (ext_edge)
  );

  assign src_w  = ctrl_q.evt_mode ? ext_edge : psc_tick;
  assign tick_w = run_q && src_w && !block_w;

  // Counter and preload.
  logic [CNT_W-1:0] cnt_q, pre_q;
  logic             ovf;

  evt_timer_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk      (clk),
    .tick     (tick_w),
    .load_cnt (wr_cnt && !run_q),
    .load_pre (wr_cnt),
    .wdata    (reg_wdata),
    .cnt_o    (cnt_q),
    .pre_o    (pre_q),
    .ovf_o    (ovf)
  );

  // Request flag, enable and wake.
  logic flag_q, ien_q;

  evt_timer_irq u_irq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .ovf         (ovf),
    .pwr_down    (pwr_down),
    .wr_int      (wr_int),
    .wr_en_bit   (reg_wdata[0]),
    .wr_flag_bit (reg_wdata[1]),
    .flag_o      (flag_q),
    .ien_o       (ien_q),
    .irq         (irq),
    .wake        (wake)
  );

  // Read mux.
  always_comb begin
    reg_rdata = '0;
    if (sel_cnt) begin
      reg_rdata = cnt_q;
    end else if (sel_ctrl) begin
      reg_rdata = CNT_W'(ctrl_q);
    end else if (sel_int) begin
      reg_rdata = CNT_W'({flag_q, ien_q});
    end
  end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       wdata_lo,
  input logic             pwr_down,
  input logic             irq,
  input logic             wake,
  input logic             run_q,
  input logic             ovf,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] pre_q
);

  // R3: a stopped counter only changes through a direct load.
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(reg_wr && reg_addr == 2'd0)) |=> $stable(cnt_q));

  // R4: overflow reloads the preload value.
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == $past(pre_q)));

  // R4: overflow leaves the request flag set.
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);

  // R5: disabling the interrupt drops irq on the next cycle.
  p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !wdata_lo[0]) |=> !irq);

  // R6: overflow beats a simultaneous clearing write.
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && reg_wr && reg_addr == 2'd2 && !wdata_lo[1]) |=> flag_q);

  // R7: a count read, or a preload write while running, freezes the count.
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0 && ((reg_rd && !reg_wr) || (reg_wr && run_q)))
      |=> $stable(cnt_q));

  // R9: wake is a single-cycle pulse.
  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R9: wake only follows a power-down cycle and leaves the flag set.
  p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(pwr_down) && flag_q));

  // R10: a pending flag suppresses wake.
  p_no_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && flag_q) |=> !wake);

endmodule

bind evt_timer evt_timer_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .wdata_lo (reg_wdata[1:0]),
  .pwr_down (pwr_down),
  .irq      (irq),
  .wake     (wake),
  .run_q    (run_q),
  .ovf      (ovf),
  .flag_q   (flag_q),
  .cnt_q    (cnt_q),
  .pre_q    (pre_q)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ext_in;
  logic       pwr_down;
  logic       irq;
  logic       wake;

  int n_tests;
  int n_fail;
  bit done;

  evt_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ext_in    (ext_in),
    .pwr_down  (pwr_down),
    .irq       (irq),
    .wake      (wake)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {prescaler select, cycles after start, expected increments}.
  localparam logic [18:0] VECS [7] = '{
    {3'd0, 8'd10,  8'd5},
    {3'd0, 8'd1,   8'd0},
    {3'd0, 8'd2,   8'd1},
    {3'd1, 8'd10,  8'd2},
    {3'd2, 8'd17,  8'd2},
    {3'd3, 8'd40,  8'd2},
    {3'd7, 8'd255, 8'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1;
      repeat (4) @(negedge clk);
      ext_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic count_wake(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wake) hits++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int hits;
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n     = 1'b0;
    reg_addr  = 2'd0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_wdata = 8'h00;
    ext_in    = 1'b0;
    pwr_down  = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 wake", {7'd0, wake}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R1 ctrl", v, 8'h00);
    rd(2'd2, v); check("R1 int", v, 8'h00);

    // R2: prescaler ratios from the vector table
    foreach (VECS[i]) begin
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h20);
      wr(2'd1, 8'h10 | {5'd0, VECS[i][18:16]});
      repeat (int'(VECS[i][15:8])) @(posedge clk);
      @(negedge clk);
      rd(2'd0, v);
      check("R2 divide", v, 8'h20 + VECS[i][7:0]);
    end

    // R7: read and preload write on tick edges; R11 running write
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h10);
    @(posedge clk);
    @(negedge clk);
    reg_addr = 2'd0;
    reg_rd   = 1'b1;
    @(negedge clk);
    reg_rd   = 1'b0;
    rd(2'd0, v); check("R7 read blocks tick", v, 8'h40);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(2'd0, v); check("R2 resume", v, 8'h41);
    @(posedge clk);
    @(negedge clk);
    wr(2'd0, 8'h77);
    rd(2'd0, v); check("R7 R11 running write", v, 8'h41);

    // R3: stop holds the count
    wr(2'd1, 8'h00);
    repeat (10) @(negedge clk);
    rd(2'd0, v); check("R3 hold", v, 8'h41);

    // R11: stopped write loads counter
    wr(2'd0, 8'h5A);
    rd(2'd0, v); check("R11 stopped load", v, 8'h5A);

    // R4 R5 R9: overflow with enable on in power-down
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h01);
    pwr_down = 1'b1;
    wr(2'd1, 8'h10);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(2'd0, v); check("R4 reload", v, 8'hFE);
    rd(2'd2, v); check("R4 flag", v, 8'h03);
    check("R5 irq on", {7'd0, irq}, 8'h01);
    check("R9 wake", {7'd0, wake}, 8'h01);
    @(negedge clk);
    check("R9 wake one cycle", {7'd0, wake}, 8'h00);

    // R10: flag already set, two overflows
    count_wake(8, hits);
    check("R10 pending flag", 8'(hits), 8'h00);

    // R5: enable off with flag set
    wr(2'd2, 8'h02);
    check("R5 irq off", {7'd0, irq}, 8'h00);

    // R9: enable off, flag cleared
    wr(2'd2, 8'h00);
    count_wake(12, hits);
    check("R9 wake without enable", 8'(hits), 8'h01);

    // R6: clear lands on overflow edge
    pwr_down = 1'b0;
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R6 set wins", v, 8'h02);

    // R10: no wake outside power-down
    wr(2'd2, 8'h00);
    count_wake(12, hits);
    check("R10 awake", 8'(hits), 8'h00);
    rd(2'd2, v); check("R4 flag awake", v, 8'h02);

    // R6: plain clear
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R6 clear", v, 8'h00);

    // R8: rising edges in event mode, during power-down
    pwr_down = 1'b1;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h30);
    pulse(3);
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R8 rising", v, 8'h03);

    // R8: falling edges
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h38);
    pulse(2);
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R8 falling", v, 8'h02);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule